// File: doc/BRIEF.md
# RC4 Key-Scheduling Unit

This block is a memory-mapped execution unit that prepares the 256-byte permutation state of an RC4-style stream cipher. Software loads a key of 1 to 16 bytes into four 32-bit key words. It then writes the key length, coded as the byte count minus one. That write starts the key-scheduling pass. The pass fills the state array with the identity permutation. It then mixes the key into the array with 256 read-and-swap steps, all on a single-port byte RAM.

When the pass ends, the unit raises an interrupt status flag. A mask bit gates the interrupt pin but never the flag. A write to the clear-interrupt location drops both the flag and the pin. A control write can issue a software reset, which acts like the hardware reset and is released automatically on the next cycle. While the unit is idle, the read port returns either the status word or any byte of the state array.

Top module: `rc4_ksa_unit`

## Requirements
- R1: Key byte k (0 to 15) is byte k mod 4, counted from the least significant byte, of key word k/4. Key words are written at wr_addr 0 (low) to 3 (upper). After a pass, the state array equals the RC4 key schedule computed with the first len+1 key bytes, repeating cyclically.
- R2: A write to wr_addr 4 loads the 4-bit length from wr_data[3:0] and starts a pass. Busy (status bit 0) is high from the cycle after that write for exactly 1280 cycles (256 fill cycles plus 4 cycles per mixing step).
- R3: While busy, writes to the key words or to the length location are ignored. The pass neither restarts nor changes its result.
- R4: At the end of a pass, the interrupt flag (status bit 1) is set. irq_o is high exactly when the flag is set and the mask is clear.
- R5: A write to wr_addr 6 clears the flag and irq_o, whatever the data. If it falls in the same cycle as the end of a pass, the completion wins and the flag stays set.
- R6: After hardware reset (rst_n low, asynchronous), the status reads busy 0, flag 0, mask 1, and irq_o is 0.
- R7: A control write (wr_addr 5) with bit 30 set resets the unit on the following cycle, exactly as R6 does, and aborts any pass. The reset request clears itself, so a later control write takes effect.
- R8: Control bit 31 is the interrupt mask (1 = pin disabled). It is written by any control write, reads back as status bit 2, and gates irq_o only, never the status flag.
- R9: rd_data is combinational. With rd_addr[8]=1 it returns the status word {29'b0, mask, flag, busy}. With rd_addr[8]=0 it returns state byte rd_addr[7:0], zero-extended, while idle, and 0 while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Write target: 0-3 key words, 4 length, 5 control, 6 clear interrupt |
| wr_data | input | 32 | Write data |
| rd_addr | input | 9 | Read select: bit 8 picks status, else a state byte index |
| rd_data | output | 32 | Read data |
| irq_o | output | 1 | Interrupt pin, flag gated by the mask |

## Verification
A clear-interrupt write and the end of a pass can land on the same clock edge. In that case one wants to drop the flag and the other wants to raise it. The bench counts cycles from the length write, presents a clear-interrupt write for exactly the 1280th edge, and then expects the flag still set with busy low. A separate case checks that a clear issued a cycle later does drop the flag, so the priority is proven on that single edge only.

// File: rtl/rc4_ksa_unit.sv
module rc4_ksa_unit #(
  parameter int DW    = 32,
  parameter int IDX_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [8:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq_o
);
  localparam int N        = 1 << IDX_W;
  localparam int MSK_BIT  = DW - 1;
  localparam int SRST_BIT = DW - 2;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_RDI, S_RDJ, S_WRI, S_WRJ} st_t;

  st_t              st;
  logic [IDX_W-1:0] i_q, j_q, si_q, sj_q;
  logic [3:0]       kc_q, klen_q;
  logic [31:0]      kw_q [4];
  logic             mask_q, irq_q, srst_q;
  logic [IDX_W-1:0] mem [N];

  logic             busy, fin, ram_we;
  logic [IDX_W-1:0] ram_a, ram_d, ram_q, kbyte;
  logic             wr_key, wr_len, wr_ctl, wr_clr;

  assign busy   = (st != S_IDLE);
  assign fin    = (st == S_WRJ) && (i_q == LAST);
  assign wr_key = wr_en && (wr_addr[2] == 1'b0) && !busy;
  assign wr_len = wr_en && (wr_addr == 3'd4) && !busy;
  assign wr_ctl = wr_en && (wr_addr == 3'd5);
  assign wr_clr = wr_en && (wr_addr == 3'd6);
  assign kbyte  = kw_q[kc_q[3:2]][8*kc_q[1:0] +: 8];

  always_comb begin
    ram_a  = rd_addr[IDX_W-1:0];
    ram_d  = '0;
    ram_we = 1'b0;
    case (st)
      S_INIT: begin ram_a = i_q; ram_d = i_q;  ram_we = 1'b1; end
      S_RDI:  ram_a = i_q;
      S_RDJ:  ram_a = j_q;
      S_WRI:  begin ram_a = i_q; ram_d = sj_q; ram_we = 1'b1; end
      S_WRJ:  begin ram_a = j_q; ram_d = si_q; ram_we = 1'b1; end
      default: ;
    endcase
  end

  assign ram_q = mem[ram_a];

  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_a] <= ram_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; i_q <= '0; j_q <= '0; si_q <= '0; sj_q <= '0;
      kc_q <= '0; klen_q <= '0; mask_q <= 1'b1; irq_q <= 1'b0; srst_q <= 1'b0;
      for (int w = 0; w < 4; w++) kw_q[w] <= '0;
    end else if (srst_q) begin
      st <= S_IDLE; i_q <= '0; j_q <= '0; si_q <= '0; sj_q <= '0;
      kc_q <= '0; klen_q <= '0; mask_q <= 1'b1; irq_q <= 1'b0; srst_q <= 1'b0;
      for (int w = 0; w < 4; w++) kw_q[w] <= '0;
    end else begin
      srst_q <= wr_ctl && wr_data[SRST_BIT];
      if (wr_ctl) mask_q <= wr_data[MSK_BIT];
      if (wr_clr) irq_q <= 1'b0;
      if (wr_key) kw_q[wr_addr[1:0]] <= wr_data[31:0];
      if (wr_len) begin
        klen_q <= wr_data[3:0];
        i_q    <= '0;
        st     <= S_INIT;
      end
      case (st)
        S_INIT: begin
          i_q <= i_q + 1'b1;
          if (i_q == LAST) begin
            j_q  <= '0;
            kc_q <= '0;
            st   <= S_RDI;
          end
        end
        S_RDI: begin
          si_q <= ram_q;
          j_q  <= j_q + ram_q + kbyte;
          st   <= S_RDJ;
        end
        S_RDJ: begin
          sj_q <= ram_q;
          st   <= S_WRI;
        end
        S_WRI: st <= S_WRJ;
        S_WRJ: begin
          i_q  <= i_q + 1'b1;
          kc_q <= (kc_q == klen_q) ? 4'd0 : kc_q + 4'd1;
          if (fin) begin
            st    <= S_IDLE;
            irq_q <= 1'b1;
          end else begin
            st <= S_RDI;
          end
        end
        default: ;
      endcase
    end
  end

  assign irq_o   = irq_q && !mask_q;
  assign rd_data = rd_addr[8] ? DW'({mask_q, irq_q, busy})
                 : (busy ? '0 : DW'(ram_q));
endmodule

module rc4_ksa_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       fin,
  input logic       srst_q,
  input logic       irq_q,
  input logic       mask_q,
  input logic       irq_o,
  input logic [3:0] klen_q,
  input logic       wr_en,
  input logic [2:0] wr_addr
);
  AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q); // R7
  AST_SRST_IDLE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (mask_q && !busy && !irq_q)); // R7
  AST_LEN_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !srst_q) |=> $stable(klen_q)); // R3
  AST_DONE_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !srst_q) |=> (irq_q && !busy)); // R4
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd6 && !fin) |=> !irq_q); // R5
  AST_PIN_FOLLOWS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_q && $rose(irq_q)) |-> irq_o); // R8
endmodule

bind rc4_ksa_unit rc4_ksa_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .fin(fin), .srst_q(srst_q),
  .irq_q(irq_q), .mask_q(mask_q), .irq_o(irq_o), .klen_q(klen_q),
  .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/sim_rc4_ksa_unit.sv
module sim_rc4_ksa_unit;
  localparam int CLK_P  = 10;
  localparam int KS_CYC = 1280;
  localparam int NV     = 4;
  localparam logic [127:0] VK [NV] = '{
    128'h00000000_00000000_00000000_0000004B,
    128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0,
    128'h00000000_00000000_000000A7_1C93E205,
    128'hFFFFFFFF_00000000_12345678_00C0FFEE
  };
  localparam logic [3:0] VL [NV] = '{4'd0, 4'd15, 4'd4, 4'd2};

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [8:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic        irq_o;
  int errors = 0, checks = 0, cyc = 0, t0 = 0;
  logic [7:0] exp_s [256];
  logic [31:0] d;

  rc4_ksa_unit u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic load_key(input logic [127:0] k);
    for (int w = 0; w < 4; w++) wr(w[2:0], k[32*w +: 32]);
  endtask

  task automatic start(input logic [3:0] len);
    wr(3'd4, {28'b0, len}); t0 = cyc;
  endtask

  task automatic wait_to(input int n);
    while (cyc < t0 + n) @(negedge clk);
  endtask

  task automatic ksa(input logic [127:0] k, input logic [3:0] len);
    logic [7:0] j, t;
    for (int i = 0; i < 256; i++) exp_s[i] = i[7:0];
    j = 0;
    for (int i = 0; i < 256; i++) begin
      j = j + exp_s[i] + k[8*(i % (int'(len) + 1)) +: 8];
      t = exp_s[i]; exp_s[i] = exp_s[j]; exp_s[j] = t;
    end
  endtask

  task automatic chk_state(input string req);
    int bad = 0;
    logic [31:0] v;
    for (int i = 0; i < 256; i++) begin
      rd({1'b0, i[7:0]}, v);
      if (v !== {24'b0, exp_s[i]}) bad++;
    end
    chk(req, bad, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 2); rst_n = 1;
    @(negedge clk);
    rd(9'h100, d); chk("R6 status after reset", d, 32'h4);
    chk("R6 irq_o after reset", {31'b0, irq_o}, 0);

    // Table walk: R1, R2, R4, R5, R9
    for (int v = 0; v < NV; v++) begin
      load_key(VK[v]);
      start(VL[v]);
      rd(9'h100, d); chk("R2 busy right after start", d & 32'h1, 1);
      wait_to(KS_CYC - 1);
      rd(9'h100, d); chk("R2 busy on last pass cycle", d & 32'h1, 1);
      wait_to(KS_CYC);
      rd(9'h100, d); chk("R4 status done, flag set, masked", d, 32'h6);
      chk("R8 irq_o masked", {31'b0, irq_o}, 0);
      ksa(VK[v], VL[v]);
      chk_state("R1 state array vs key schedule");
      wr(3'd6, 32'hDEAD_BEEF);
      rd(9'h100, d); chk("R5 clear with arbitrary data", d, 32'h4);
    end

    // R8: mask gates only the pin
    wr(3'd5, 32'h0);
    rd(9'h100, d); chk("R8 mask cleared", d, 32'h0);
    load_key(VK[0]); start(VL[0]); wait_to(KS_CYC);
    chk("R4 irq_o with mask clear", {31'b0, irq_o}, 1);
    wr(3'd5, 32'h8000_0000);
    chk("R8 irq_o blocked by mask", {31'b0, irq_o}, 0);
    rd(9'h100, d); chk("R8 flag kept under mask", d, 32'h6);
    wr(3'd5, 32'h0);
    chk("R8 irq_o back after unmask", {31'b0, irq_o}, 1);
    wr(3'd6, 32'h0);
    chk("R5 irq_o dropped by clear", {31'b0, irq_o}, 0);

    // R3: writes while busy ignored; R9: state reads zero while busy
    load_key(VK[1]); start(VL[1]);
    wait_to(100);
    rd(9'h000, d); chk("R9 state read while busy", d, 0);
    load_key(128'h5555_AAAA_1234_9876_0101_0202_7777_8888);
    wr(3'd4, 32'h0);
    wait_to(KS_CYC - 1);
    rd(9'h100, d); chk("R3 length write did not restart", d & 32'h1, 1);
    wait_to(KS_CYC);
    rd(9'h100, d); chk("R3 pass ended on time", d & 32'h1, 0);
    ksa(VK[1], VL[1]);
    chk_state("R3 result uses original key");
    wr(3'd6, 32'h0);

    // R5: clear on the completion edge, completion wins
    start(VL[1]);
    wait_to(KS_CYC - 1);
    wr_en = 1; wr_addr = 3'd6; wr_data = 32'hFFFF_FFFF;
    @(negedge clk); wr_en = 0;
    rd(9'h100, d); chk("R5 completion beats same-cycle clear", d & 32'h3, 32'h2);
    wr(3'd6, 32'h0);
    rd(9'h100, d); chk("R5 later clear drops flag", d & 32'h3, 0);

    // R7: soft reset aborts a pass and releases itself
    start(VL[2]);
    wait_to(50);
    wr(3'd5, 32'h4000_0000);
    @(negedge clk);
    rd(9'h100, d); chk("R7 soft reset state", d, 32'h4);
    chk("R7 irq_o after soft reset", {31'b0, irq_o}, 0);
    wr(3'd5, 32'h0);
    rd(9'h100, d); chk("R7 soft reset self-cleared", d, 32'h0);

    // R6: hardware reset mid-pass
    start(VL[2]);
    wait_to(30);
    rst_n = 0; #1;
    rd(9'h100, d); chk("R6 hardware reset mid-pass", d, 32'h4);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    rd(9'h100, d); chk("R6 idle after release", d, 32'h4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule